// File: doc/BRIEF.md
# Cycle-Programmable Byte Datapath

This block is an 8-bit arithmetic engine whose whole behaviour is chosen again on every clock edge. A 3-bit selector picks one of eight stored 16-bit control words. That word decides the ALU function, the two operand sources, a post-ALU shift, an optional mask, which accumulators take the result, and which byte queues move data. A sequencer or other control logic drives the selector cycle by cycle, so the same hardware can act as a counter on one cycle and as an adder or a queue mover on the next.

The block holds two accumulators, two data registers, a mask register and two 4-entry byte queues. A simple host port can write and read all of these. Host writes and reads to a queue address push and pop that queue. The control words are loaded through a separate write port. The block drives unsigned compare flags and zero/carry flags combinationally from the current state and the active word.

Top module: `dyn_datapath`

## Requirements
- R1: After reset, A0, A1, D0, D1 and the error register read 0, the mask reads 8'hFF, both queues are empty, and every control word is 16'h0000.
- R2: When cfg_we is high at a clock edge, cfg_wdata is stored at cfg_waddr and is used from the next cycle on. In every cycle the word stored at cfg_sel controls the datapath.
- R3: The function field, word bits [2:0], selects the ALU operation on operands A and B: 0 pass A, 1 A+1, 2 A-1, 3 A+B, 4 A-B, 5 A AND B, 6 A OR B, 7 A XOR B. The result is 8 bits, modulo 256.
- R4: carry_flag is the carry out of codes 1 and 3, the borrow of codes 2 and 4, and 0 for the other codes. zero_flag is high when the final result after shift and mask is 0.
- R5: Bits [4:3] select operand A and bits [6:5] select operand B, with the encoding 0 A0, 1 A1, 2 D0, 3 D1. Bits [11:10] choose where the final result is written: 0 nowhere, 1 A0, 2 A1, 3 both.
- R6: Bits [8:7] shift the ALU result: 0 none, 1 left by one with 0 fill, 2 right by one with 0 fill, 3 swap the two nibbles.
- R7: When bit 9 is set, the shifted result is ANDed with the mask register.
- R8: a0_eq_d0, a0_lt_d0, a1_eq_d1 and a1_lt_d1 report the unsigned compares A0==D0, A0<D0, A1==D1 and A1<D1.
- R9: Each queue holds 4 bytes in first-in first-out order and reports empty and full.
- R10: Bit 12 pushes the final result into F0. Bit 13 pops F0 into D0. Bit 14 pops F1 into D1. Bit 15 pushes the value A0 held before the edge into F1.
- R11: A push to a full queue or a pop from an empty queue is ignored. This holds even when the opposite operation happens in the same cycle. The rejected operation sets a sticky error bit: bit 0 for F0 overflow, bit 1 for F0 underflow, bit 2 for F1 overflow, bit 3 for F1 underflow. A host write to the error register clears the bits written as 1. A new error in the same cycle wins over the clear.
- R12: A host write beats a datapath update of the same register. When the host and the datapath push the same queue in the same cycle, only the host byte is queued. When both pop the same queue in the same cycle, one entry is removed.
- R13: Host addresses are 0 A0, 1 A1, 2 D0, 3 D1, 4 F0, 5 F1, 6 mask, 7 error register (bits [3:0], upper bits 0). host_rdata shows the addressed register, or the head of the addressed queue (0 when that queue is empty). host_wr to a queue pushes and host_rd from a queue pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sel | input | 3 | Index of the control word in force this cycle |
| cfg_we | input | 1 | Control word write strobe |
| cfg_waddr | input | 3 | Control word write index |
| cfg_wdata | input | 16 | Control word write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops a queue address) |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| a0_eq_d0 | output | 1 | A0 equals D0 |
| a0_lt_d0 | output | 1 | A0 below D0, unsigned |
| a1_eq_d1 | output | 1 | A1 equals D1 |
| a1_lt_d1 | output | 1 | A1 below D1, unsigned |
| zero_flag | output | 1 | Final result is zero |
| carry_flag | output | 1 | ALU carry or borrow |
| f0_empty | output | 1 | F0 holds no byte |
| f0_full | output | 1 | F0 holds four bytes |
| f1_empty | output | 1 | F1 holds no byte |
| f1_full | output | 1 | F1 holds four bytes |

## Verification
Host access and the programmed datapath can hit the same register or queue in one cycle. Examples are a host write to A0 while the active word targets A0, a host push and an ALU push into F0 together, a host pop and a pop-into-D0 together, and an error-register clear in the same cycle as a fresh underflow. Directed sequences arrange each of these collisions. A long stretch of random control words, selectors and host traffic then mixes them freely. A behavioural model with byte queues predicts every register, flag and queue level. The model applies the priority rules as stated, and the bench compares it to the outputs on every cycle.

// File: rtl/dpath_pkg.sv
package dpath_pkg;
  localparam int CFGW = 16;

  typedef enum logic [2:0] {
    FN_PASS, FN_INC, FN_DEC, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR
  } alu_fn_e;

  typedef enum logic [1:0] {SRC_A0, SRC_A1, SRC_D0, SRC_D1} src_e;
  typedef enum logic [1:0] {SH_NONE, SH_LEFT, SH_RIGHT, SH_SWAP} shift_e;
  typedef enum logic [1:0] {DST_NONE, DST_A0, DST_A1, DST_BOTH} dest_e;

  typedef struct packed {
    logic    f1_push_a0;
    logic    f1_pop_d1;
    logic    f0_pop_d0;
    logic    f0_push_res;
    dest_e   dest;
    logic    mask_en;
    shift_e  shift;
    src_e    opb;
    src_e    opa;
    alu_fn_e fn;
  } cfg_word_t;

  localparam logic [2:0] HA_A0   = 3'd0;
  localparam logic [2:0] HA_A1   = 3'd1;
  localparam logic [2:0] HA_D0   = 3'd2;
  localparam logic [2:0] HA_D1   = 3'd3;
  localparam logic [2:0] HA_F0   = 3'd4;
  localparam logic [2:0] HA_F1   = 3'd5;
  localparam logic [2:0] HA_MASK = 3'd6;
  localparam logic [2:0] HA_ERR  = 3'd7;
endpackage

// File: rtl/dp_cfg_store.sv
module dp_cfg_store #(
  parameter int W  = 16,
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] sel,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] word_q [N];
  logic [W-1:0] word_d [N];

  for (genvar g = 0; g < N; g++) begin : g_word
    always_comb begin
      word_d[g] = word_q[g];
      if (we && (waddr == AW'(g))) word_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[g] <= '0;
      else        word_q[g] <= word_d[g];
    end
  end

  assign rdata = word_q[sel];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dpath_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] mask,
  input  alu_fn_e      fn,
  input  shift_e       shift,
  input  logic         mask_en,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         zero
);
  localparam int HW = W / 2;

  logic [W:0]   wide;
  logic [W-1:0] sh;

  always_comb begin
    unique case (fn)
      FN_PASS: wide = {1'b0, opa};
      FN_INC:  wide = {1'b0, opa} + {{W{1'b0}}, 1'b1};
      FN_DEC:  wide = {1'b0, opa} - {{W{1'b0}}, 1'b1};
      FN_ADD:  wide = {1'b0, opa} + {1'b0, opb};
      FN_SUB:  wide = {1'b0, opa} - {1'b0, opb};
      FN_AND:  wide = {1'b0, opa & opb};
      FN_OR:   wide = {1'b0, opa | opb};
      FN_XOR:  wide = {1'b0, opa ^ opb};
      default: wide = '0;
    endcase
  end

  always_comb begin
    unique case (shift)
      SH_NONE:  sh = wide[W-1:0];
      SH_LEFT:  sh = {wide[W-2:0], 1'b0};
      SH_RIGHT: sh = {1'b0, wide[W-1:1]};
      SH_SWAP:  sh = {wide[HW-1:0], wide[W-1:HW]};
      default:  sh = wide[W-1:0];
    endcase
  end

  assign res   = mask_en ? (sh & mask) : sh;
  assign carry = wide[W];
  assign zero  = (res == '0);
endmodule

// File: rtl/dp_byte_fifo.sv
module dp_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         push_rej,
  output logic         pop_rej
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign push_rej = push && full;
  assign pop_rej  = pop && empty;
  assign dout     = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= din;
  end
endmodule

// File: rtl/dyn_datapath.sv
module dyn_datapath
  import dpath_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int NCFG  = 8,
  parameter int SELW  = $clog2(NCFG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] cfg_sel,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_waddr,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [2:0]      host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            a0_eq_d0,
  output logic            a0_lt_d0,
  output logic            a1_eq_d1,
  output logic            a1_lt_d1,
  output logic            zero_flag,
  output logic            carry_flag,
  output logic            f0_empty,
  output logic            f0_full,
  output logic            f1_empty,
  output logic            f1_full
);
  localparam int NQ   = 2;
  localparam int ERRW = 2 * NQ;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // active control word
  logic [CFGW-1:0] cw_raw;
  cfg_word_t       cw;

  dp_cfg_store #(.W(CFGW), .N(NCFG), .AW(SELW)) u_cfg (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (cfg_we),
    .waddr (cfg_waddr),
    .wdata (cfg_wdata),
    .sel   (cfg_sel),
    .rdata (cw_raw)
  );
  assign cw = cfg_word_t'(cw_raw);

  // working registers
  logic [DW-1:0]   a0_q, a1_q, d0_q, d1_q, mask_q;
  logic [DW-1:0]   a0_d, a1_d, d0_d, d1_d, mask_d;
  logic [ERRW-1:0] err_q, err_d, err_clr;
  logic            a0_en, a1_en, d0_en, d1_en, mask_en_r, err_en;

  // operand selection
  logic [DW-1:0] opa, opb;

  function automatic logic [DW-1:0] pick(input src_e s, input logic [DW-1:0] r0,
                                         input logic [DW-1:0] r1, input logic [DW-1:0] r2,
                                         input logic [DW-1:0] r3);
    unique case (s)
      SRC_A0:  pick = r0;
      SRC_A1:  pick = r1;
      SRC_D0:  pick = r2;
      SRC_D1:  pick = r3;
      default: pick = r0;
    endcase
  endfunction

  assign opa = pick(cw.opa, a0_q, a1_q, d0_q, d1_q);
  assign opb = pick(cw.opb, a0_q, a1_q, d0_q, d1_q);

  logic [DW-1:0] alu_res;

  dp_alu #(.W(DW)) u_alu (
    .opa     (opa),
    .opb     (opb),
    .mask    (mask_q),
    .fn      (cw.fn),
    .shift   (cw.shift),
    .mask_en (cw.mask_en),
    .res     (alu_res),
    .carry   (carry_flag),
    .zero    (zero_flag)
  );

  // host decode
  logic hw_a0, hw_a1, hw_d0, hw_d1, hw_mask, hw_err;
  logic hw_q [NQ];
  logic hr_q [NQ];

  assign hw_a0   = host_wr && (host_addr == HA_A0);
  assign hw_a1   = host_wr && (host_addr == HA_A1);
  assign hw_d0   = host_wr && (host_addr == HA_D0);
  assign hw_d1   = host_wr && (host_addr == HA_D1);
  assign hw_mask = host_wr && (host_addr == HA_MASK);
  assign hw_err  = host_wr && (host_addr == HA_ERR);
  assign hw_q[0] = host_wr && (host_addr == HA_F0);
  assign hw_q[1] = host_wr && (host_addr == HA_F1);
  assign hr_q[0] = host_rd && (host_addr == HA_F0);
  assign hr_q[1] = host_rd && (host_addr == HA_F1);

  // queues: index 0 takes ALU results, index 1 takes A0
  logic          dp_push [NQ];
  logic          dp_pop  [NQ];
  logic [DW-1:0] dp_din  [NQ];
  logic          q_push  [NQ];
  logic          q_pop   [NQ];
  logic [DW-1:0] q_din   [NQ];
  logic [DW-1:0] q_dout  [NQ];
  logic          q_empty [NQ];
  logic          q_full  [NQ];
  logic          q_prej  [NQ];
  logic          q_orej  [NQ];

  assign dp_push[0] = cw.f0_push_res;
  assign dp_pop[0]  = cw.f0_pop_d0;
  assign dp_din[0]  = alu_res;
  assign dp_push[1] = cw.f1_push_a0;
  assign dp_pop[1]  = cw.f1_pop_d1;
  assign dp_din[1]  = a0_q;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assign q_push[i] = hw_q[i] || dp_push[i];
    assign q_pop[i]  = hr_q[i] || dp_pop[i];
    assign q_din[i]  = hw_q[i] ? host_wdata : dp_din[i];

    dp_byte_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (srst_n),
      .push     (q_push[i]),
      .pop      (q_pop[i]),
      .din      (q_din[i]),
      .dout     (q_dout[i]),
      .empty    (q_empty[i]),
      .full     (q_full[i]),
      .push_rej (q_prej[i]),
      .pop_rej  (q_orej[i])
    );
  end

  // next state; host writes applied last so they win
  always_comb begin
    a0_en     = (cw.dest == DST_A0) || (cw.dest == DST_BOTH) || hw_a0;
    a1_en     = (cw.dest == DST_A1) || (cw.dest == DST_BOTH) || hw_a1;
    d0_en     = (cw.f0_pop_d0 && !q_empty[0]) || hw_d0;
    d1_en     = (cw.f1_pop_d1 && !q_empty[1]) || hw_d1;
    mask_en_r = hw_mask;
    a0_d      = hw_a0 ? host_wdata : alu_res;
    a1_d      = hw_a1 ? host_wdata : alu_res;
    d0_d      = hw_d0 ? host_wdata : q_dout[0];
    d1_d      = hw_d1 ? host_wdata : q_dout[1];
    mask_d    = host_wdata;
    err_clr   = hw_err ? host_wdata[ERRW-1:0] : '0;
    err_d     = (err_q & ~err_clr) | {q_orej[1], q_prej[1], q_orej[0], q_prej[0]};
    err_en    = hw_err || q_prej[0] || q_orej[0] || q_prej[1] || q_orej[1];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      a0_q   <= '0;
      a1_q   <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      mask_q <= '1;
      err_q  <= '0;
    end else begin
      if (a0_en)     a0_q   <= a0_d;
      if (a1_en)     a1_q   <= a1_d;
      if (d0_en)     d0_q   <= d0_d;
      if (d1_en)     d1_q   <= d1_d;
      if (mask_en_r) mask_q <= mask_d;
      if (err_en)    err_q  <= err_d;
    end
  end

  // host read mux
  always_comb begin
    unique case (host_addr)
      HA_A0:   host_rdata = a0_q;
      HA_A1:   host_rdata = a1_q;
      HA_D0:   host_rdata = d0_q;
      HA_D1:   host_rdata = d1_q;
      HA_F0:   host_rdata = q_empty[0] ? '0 : q_dout[0];
      HA_F1:   host_rdata = q_empty[1] ? '0 : q_dout[1];
      HA_MASK: host_rdata = mask_q;
      default: host_rdata = {{(DW-ERRW){1'b0}}, err_q};
    endcase
  end

  assign a0_eq_d0 = (a0_q == d0_q);
  assign a0_lt_d0 = (a0_q <  d0_q);
  assign a1_eq_d1 = (a1_q == d1_q);
  assign a1_lt_d1 = (a1_q <  d1_q);
  assign f0_empty = q_empty[0];
  assign f0_full  = q_full[0];
  assign f1_empty = q_empty[1];
  assign f1_full  = q_full[1];
endmodule

// File: rtl/dyn_datapath_chk.sv
module dyn_datapath_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          srst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic [2:0]    host_addr,
  input logic [DW-1:0] host_wdata,
  input logic [DW-1:0] a0_q,
  input logic [3:0]    err_q,
  input logic          f0_empty,
  input logic          f0_full,
  input logic          f1_empty,
  input logic          f1_full,
  input logic          a0_eq_d0,
  input logic          a0_lt_d0,
  input logic          a1_eq_d1,
  input logic          a1_lt_d1
);
  p_f0_flags_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !(f0_empty && f0_full));

  p_f1_flags_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !(f1_empty && f1_full));

  p_cmp0_excl_r8: assert property (@(posedge clk) disable iff (!srst_n)
    a0_eq_d0 |-> !a0_lt_d0);

  p_cmp1_excl_r8: assert property (@(posedge clk) disable iff (!srst_n)
    a1_eq_d1 |-> !a1_lt_d1);

  p_host_a0_wins_r12: assert property (@(posedge clk) disable iff (!srst_n)
    (host_wr && host_addr == 3'd0) |=> (a0_q == $past(host_wdata)));

  p_f0_overflow_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (host_wr && host_addr == 3'd4 && f0_full) |=> err_q[0]);

  p_f0_underflow_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (host_rd && host_addr == 3'd4 && f0_empty) |=> err_q[1]);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (($past(err_q) & ~(($past(host_wr) && $past(host_addr) == 3'd7) ?
       $past(host_wdata[3:0]) : 4'h0) & ~err_q) == 4'h0));
endmodule

bind dyn_datapath dyn_datapath_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .a0_q       (a0_q),
  .err_q      (err_q),
  .f0_empty   (f0_empty),
  .f0_full    (f0_full),
  .f1_empty   (f1_empty),
  .f1_full    (f1_full),
  .a0_eq_d0   (a0_eq_d0),
  .a0_lt_d0   (a0_lt_d0),
  .a1_eq_d1   (a1_eq_d1),
  .a1_lt_d1   (a1_lt_d1)
);

// File: tb/dyn_datapath_test.sv
`timescale 1ns/1ps
module dyn_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_sel, cfg_waddr, host_addr;
  logic        cfg_we, host_wr, host_rd;
  logic [15:0] cfg_wdata;
  logic [7:0]  host_wdata, host_rdata;
  logic        a0_eq_d0, a0_lt_d0, a1_eq_d1, a1_lt_d1, zero_flag, carry_flag;
  logic        f0_empty, f0_full, f1_empty, f1_full;

  always #10 clk = ~clk;

  dyn_datapath uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .a0_eq_d0(a0_eq_d0), .a0_lt_d0(a0_lt_d0),
    .a1_eq_d1(a1_eq_d1), .a1_lt_d1(a1_lt_d1), .zero_flag(zero_flag),
    .carry_flag(carry_flag), .f0_empty(f0_empty), .f0_full(f0_full),
    .f1_empty(f1_empty), .f1_full(f1_full)
  );

  int n_checks = 0;
  int n_errs   = 0;

  // reference model state
  int        m_a0, m_a1, m_d0, m_d1, m_mask, m_err;
  int        q0[$];
  int        q1[$];
  int        m_cfg[8];

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int src(input int s);
    case (s)
      0: return m_a0;
      1: return m_a1;
      2: return m_d0;
      default: return m_d1;
    endcase
  endfunction

  function automatic int mk(input int fn, input int a, input int b, input int sh,
                            input int men, input int dst, input int f0push,
                            input int f0pop, input int f1pop, input int f1push);
    return fn | (a << 3) | (b << 5) | (sh << 7) | (men << 9) | (dst << 10)
         | (f0push << 12) | (f0pop << 13) | (f1pop << 14) | (f1push << 15);
  endfunction

  task automatic model_alu(input int w, output int res, output int cy, output int z);
    int a, b, r;
    a = src((w >> 3) & 3);
    b = src((w >> 5) & 3);
    case (w & 7)
      0: r = a;
      1: r = a + 1;
      2: r = a - 1;
      3: r = a + b;
      4: r = a - b;
      5: r = a & b;
      6: r = a | b;
      default: r = a ^ b;
    endcase
    cy = (r > 255 || r < 0) ? 1 : 0;
    r = r & 255;
    case ((w >> 7) & 3)
      1: r = (r << 1) & 255;
      2: r = r >> 1;
      3: r = ((r & 15) << 4) | (r >> 4);
      default: ;
    endcase
    if ((w >> 9) & 1) r = r & m_mask;
    res = r;
    z = (r == 0) ? 1 : 0;
  endtask

  // compare outputs for the current inputs, then advance one clock
  task automatic tick(input string tag);
    int w, res, cy, z, exp_rd;
    int n_a0, n_a1, n_d0, n_d1, n_mask, n_err, setb, clr;
    int s0, s1, push0, pop0, push1, pop1, din0, din1, h0, h1;
    #2;
    w = m_cfg[cfg_sel];
    model_alu(w, res, cy, z);
    case (host_addr)
      0: exp_rd = m_a0;
      1: exp_rd = m_a1;
      2: exp_rd = m_d0;
      3: exp_rd = m_d1;
      4: exp_rd = (q0.size() > 0) ? q0[0] : 0;
      5: exp_rd = (q1.size() > 0) ? q1[0] : 0;
      6: exp_rd = m_mask;
      default: exp_rd = m_err;
    endcase
    check(tag, "rdata", int'(host_rdata), exp_rd);
    check("R4", "zero/carry", int'({zero_flag, carry_flag}), (z << 1) | cy);
    check("R8", "compares", int'({a0_eq_d0, a0_lt_d0, a1_eq_d1, a1_lt_d1}),
          ((m_a0 == m_d0) << 3) | ((m_a0 < m_d0) << 2) | ((m_a1 == m_d1) << 1) | (m_a1 < m_d1));
    check("R9", "queue status", int'({f0_empty, f0_full, f1_empty, f1_full}),
          ((q0.size() == 0) << 3) | ((q0.size() == 4) << 2) | ((q1.size() == 0) << 1) | (q1.size() == 4));

    s0 = q0.size();
    s1 = q1.size();
    h0 = (s0 > 0) ? q0[0] : 0;
    h1 = (s1 > 0) ? q1[0] : 0;
    push0 = (host_wr && host_addr == 4) || ((w >> 12) & 1);
    din0  = (host_wr && host_addr == 4) ? host_wdata : res;
    pop0  = (host_rd && host_addr == 4) || ((w >> 13) & 1);
    push1 = (host_wr && host_addr == 5) || ((w >> 15) & 1);
    din1  = (host_wr && host_addr == 5) ? host_wdata : m_a0;
    pop1  = (host_rd && host_addr == 5) || ((w >> 14) & 1);
    setb = 0;
    if (push0 && s0 == 4) setb |= 1;
    if (pop0 && s0 == 0)  setb |= 2;
    if (push1 && s1 == 4) setb |= 4;
    if (pop1 && s1 == 0)  setb |= 8;
    n_a0 = m_a0; n_a1 = m_a1; n_d0 = m_d0; n_d1 = m_d1; n_mask = m_mask;
    case ((w >> 10) & 3)
      1: n_a0 = res;
      2: n_a1 = res;
      3: begin n_a0 = res; n_a1 = res; end
      default: ;
    endcase
    if (((w >> 13) & 1) && s0 > 0) n_d0 = h0;
    if (((w >> 14) & 1) && s1 > 0) n_d1 = h1;
    clr = 0;
    if (host_wr) begin
      case (host_addr)
        0: n_a0 = host_wdata;
        1: n_a1 = host_wdata;
        2: n_d0 = host_wdata;
        3: n_d1 = host_wdata;
        6: n_mask = host_wdata;
        7: clr = host_wdata & 15;
        default: ;
      endcase
    end
    n_err = (m_err & ~clr & 15) | setb;

    @(posedge clk);
    m_a0 = n_a0; m_a1 = n_a1; m_d0 = n_d0; m_d1 = n_d1; m_mask = n_mask; m_err = n_err;
    if (pop0 && s0 > 0) void'(q0.pop_front());
    if (push0 && s0 < 4) q0.push_back(din0);
    if (pop1 && s1 > 0) void'(q1.pop_front());
    if (push1 && s1 < 4) q1.push_back(din1);
    if (cfg_we) m_cfg[cfg_waddr] = cfg_wdata;
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 0; cfg_waddr = 0; cfg_wdata = 0;
    host_wr = 0; host_rd = 0; host_wdata = 0;
  endtask

  task automatic hwrite(input int addr, input int data, input string tag);
    host_wr = 1; host_addr = addr[2:0]; host_wdata = data[7:0];
    tick(tag);
    host_wr = 0;
  endtask

  task automatic hread(input int addr, input string tag);
    host_rd = 1; host_addr = addr[2:0];
    tick(tag);
    host_rd = 0;
  endtask

  task automatic cfgw(input int idx, input int word);
    cfg_we = 1; cfg_waddr = idx[2:0]; cfg_wdata = word[15:0];
    tick("R2");
    cfg_we = 0;
  endtask

  // program slot 1, run it once, then look at the chosen register
  task automatic run1(input int word, input int look, input string tag);
    cfgw(1, word);
    cfg_sel = 1; host_addr = look[2:0];
    tick(tag);
    cfg_sel = 0;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    int vals[6];
    rst_n = 0; cfg_sel = 0; host_addr = 0;
    idle();
    m_a0 = 0; m_a1 = 0; m_d0 = 0; m_d1 = 0; m_mask = 255; m_err = 0;
    for (int i = 0; i < 8; i++) m_cfg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 / R13: reset values on every host address
    for (int a = 0; a < 8; a++) begin
      host_addr = a[2:0];
      tick("R1");
    end

    // R13: register writes and readback
    hwrite(0, 8'h35, "R13"); hwrite(1, 8'hF0, "R13");
    hwrite(2, 8'h35, "R13"); hwrite(3, 8'h10, "R13");
    for (int a = 0; a < 4; a++) begin host_addr = a[2:0]; tick("R13"); end

    // R3 / R4: every function on several operand pairs, result into A1
    vals = '{8'h35, 8'hFF, 8'h00, 8'h80, 8'h01, 8'hC3};
    for (int p = 0; p < 6; p++) begin
      hwrite(0, vals[p], "R3");
      hwrite(3, vals[(p + 1) % 6], "R3");
      for (int f = 0; f < 8; f++) run1(mk(f, 0, 3, 0, 0, 2, 0, 0, 0, 0), 1, "R3");
    end

    // R5: operand selectors and destinations
    hwrite(0, 8'h11, "R5"); hwrite(1, 8'h22, "R5");
    hwrite(2, 8'h44, "R5"); hwrite(3, 8'h88, "R5");
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        run1(mk(3, a, b, 0, 0, (a + b) % 4, 0, 0, 0, 0), (a + b) % 2, "R5");

    // R6: shift modes
    hwrite(2, 8'hA5, "R6");
    for (int s = 0; s < 4; s++) run1(mk(0, 2, 0, s, 0, 1, 0, 0, 0, 0), 0, "R6");
    hwrite(2, 8'h81, "R6");
    for (int s = 0; s < 4; s++) run1(mk(0, 2, 0, s, 0, 2, 0, 0, 0, 0), 1, "R6");

    // R7: mask stage on and off
    hwrite(6, 8'h0F, "R7");
    host_addr = 6; tick("R7");
    run1(mk(0, 2, 0, 0, 1, 1, 0, 0, 0, 0), 0, "R7");
    run1(mk(0, 2, 0, 3, 1, 1, 0, 0, 0, 0), 0, "R7");
    hwrite(6, 8'hF0, "R7");
    run1(mk(0, 2, 0, 0, 1, 1, 0, 0, 0, 0), 0, "R7");
    run1(mk(0, 2, 0, 0, 0, 1, 0, 0, 0, 0), 0, "R7");

    // R9 / R11: fill F0 past full, drain past empty
    for (int i = 0; i < 5; i++) hwrite(4, 8'h60 + i, "R9");
    host_addr = 7; tick("R11");
    for (int i = 0; i < 5; i++) hread(4, "R9");
    host_addr = 7; tick("R11");
    hwrite(7, 8'h01, "R11");
    hwrite(7, 8'h0F, "R11");
    // F1 through the host
    for (int i = 0; i < 5; i++) hwrite(5, 8'hB0 + i, "R9");
    for (int i = 0; i < 5; i++) hread(5, "R9");
    host_addr = 7; tick("R11");
    hwrite(7, 8'h0F, "R11");

    // R10: datapath queue moves
    hwrite(0, 8'h07, "R10");
    cfgw(2, mk(1, 0, 0, 0, 0, 1, 1, 0, 0, 1));
    cfg_sel = 2;
    host_addr = 4;
    for (int i = 0; i < 6; i++) tick("R10");
    cfg_sel = 0;
    cfgw(3, mk(0, 0, 0, 0, 0, 0, 0, 1, 1, 0));
    cfg_sel = 3; host_addr = 2;
    for (int i = 0; i < 6; i++) tick("R10");
    cfg_sel = 0; host_addr = 3; tick("R10");
    host_addr = 7; tick("R11");

    // R11: fresh underflow in the same cycle as a clear
    cfg_sel = 3;
    hwrite(7, 8'h0F, "R11");
    cfg_sel = 0;
    host_addr = 7; tick("R11");
    hwrite(7, 8'h0F, "R11");

    // R12: host write against datapath destination
    cfgw(4, mk(1, 0, 0, 0, 0, 3, 0, 0, 0, 0));
    cfg_sel = 4;
    hwrite(0, 8'h5A, "R12");
    cfg_sel = 0;
    host_addr = 0; tick("R12");
    host_addr = 1; tick("R12");
    // R12: host push against datapath push into F0
    cfgw(5, mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    cfg_sel = 5;
    hwrite(4, 8'hE1, "R12");
    cfg_sel = 0;
    host_addr = 4; tick("R12");
    hwrite(4, 8'hE2, "R12");
    // R12: host pop and datapath pop together take one entry
    cfgw(6, mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    cfg_sel = 6;
    hread(4, "R12");
    cfg_sel = 0;
    host_addr = 4; tick("R12");
    host_addr = 2; tick("R12");

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      cfg_we = ((r & 7) == 0);
      cfg_waddr = 3'($urandom);
      cfg_wdata = 16'($urandom);
      cfg_sel = 3'($urandom);
      host_addr = 3'($urandom);
      host_wdata = 8'($urandom);
      host_wr = ((r >> 4) & 3) == 0;
      host_rd = ((r >> 6) & 3) == 0;
      tick("R5");
    end
    idle();
    cfg_sel = 0;
    for (int a = 0; a < 8; a++) begin host_addr = a[2:0]; tick("R13"); end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule